// File: doc/BRIEF.md
# System Control Register File with Write Side Effects

This block holds the system control state of a processor core in one indexed register file: the mode word, the fault address, the translation table base, the feature enables, the task priority, the extended feature word, a time-stamp counter, four breakpoint addresses, the debug status and debug control words, and the floating-point and vector control and status words. One write port and one read port, each with a valid, an index and data, serve every register.

A write is not always a plain store. Each register has its own write mask, and some registers have side effects. Toggling the paging bit of the mode word can switch the long-mode-active bit of the extended feature word, and it asks both translation buffers for a full flush. Writing the table base asks for a flush of non-global entries. Toggling certain feature bits asks for a full flush. The time-stamp counter is kept as an offset from a free-running cycle count. Two debug indices are aliases of the debug status and debug control words. Flush requests leave the block as one-cycle pulses, one pair for the instruction translation buffer and one pair for the data translation buffer.

Top module: `sysctl_regfile`

## Requirements
- R1: After reset every register reads 0, except the debug status word (index 11), which reads 0x00000000FFFF0FF0, and the debug control word (index 12), which reads 0x0000000000000400.
- R2: Writes are masked by index: floating-point top (15) keeps bits 2:0, tag word (16) keeps bits 7:0, floating-point status (17), control (18) and opcode (19) keep bits 15:0, vector control/status (20) keeps bits 31:0. Every other index keeps all 64 bits.
- R3: A write to the mode word (index 0) always stores bit 4 as 1. If the write changes bit 31 (paging enable), full-flush pulses are sent to both translation buffers.
- R4: When a mode-word write changes bit 31 while bit 8 (long-mode enable) of the extended feature word (index 5) is 1, bit 10 (long-mode active) of that word takes the new bit 31. Otherwise the extended feature word is unchanged.
- R5: Every write to the table base (index 2) sends non-global flush pulses to both translation buffers.
- R6: A write to the feature word (index 3) that changes bit 4, 5 or 7 sends full-flush pulses to both translation buffers. Changes to any other bit send no flush.
- R7: A flush pulse is high for exactly the one cycle after the clock edge that commits the write. The instruction-side and data-side outputs are equal. Full and non-global flush are never high together: when both are requested, only full flush is sent.
- R8: A time-stamp write (index 6) stores the written value minus the current cycle count. A time-stamp read returns the stored value plus the cycle count at the read edge. The cycle count is 0 at the first edge after reset and grows by one each edge.
- R9: Writes to index 13 go to the debug status word (11), and writes to index 14 go to the debug control word (12). Reads of 13 and 14 return 11 and 12.
- R10: A write to the debug status word changes only bits 0-3, 13, 14 and 15. All other bits keep their values.
- R11: A read of the floating-point status word (17) returns the stored word with bits 13:11 replaced by the floating-point top (15) bits 2:0.
- R12: Read data is valid one cycle after the request and shows the state before any write in the same cycle. Indices 21 to 31 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_valid_i | input | 1 | Write request |
| wr_idx_i | input | 5 | Write register index |
| wr_data_i | input | 64 | Write data |
| rd_valid_i | input | 1 | Read request |
| rd_idx_i | input | 5 | Read register index |
| rd_valid_o | output | 1 | Read data valid, one cycle after the request |
| rd_data_o | output | 64 | Read data |
| flush_all_itlb_o | output | 1 | Full flush pulse to the instruction translation buffer |
| flush_all_dtlb_o | output | 1 | Full flush pulse to the data translation buffer |
| flush_ng_itlb_o | output | 1 | Non-global flush pulse to the instruction translation buffer |
| flush_ng_dtlb_o | output | 1 | Non-global flush pulse to the data translation buffer |

## Verification
Mode-word writes are run with paging toggled on and off, with long-mode enable both clear and set, and with bit 31 left unchanged. These cases separate a flush caused by the toggle from one caused by any write, and show whether long-mode active follows the paging bit. Feature writes flip each of the three flush bits and also an unrelated bit, and one write repeats the same value, so a wrong toggle mask shows up. Time-stamp reads at several distances from the write tell an offset store apart from a plain store. Alias, debug-status and out-of-range writes are each followed by reads of the target and of its neighbours.

// File: rtl/crf_pkg.sv
package crf_pkg;

    localparam int XLEN     = 64;
    localparam int IDX_W    = 5;
    localparam int NUM_REGS = 21;
    localparam int N_TLB    = 2;

    // register indices
    localparam logic [IDX_W-1:0] IDX_MODE       = 5'd0;
    localparam logic [IDX_W-1:0] IDX_FAULT_ADDR = 5'd1;
    localparam logic [IDX_W-1:0] IDX_TABLE_BASE = 5'd2;
    localparam logic [IDX_W-1:0] IDX_FEATURE    = 5'd3;
    localparam logic [IDX_W-1:0] IDX_PRIO       = 5'd4;
    localparam logic [IDX_W-1:0] IDX_EXT_FEAT   = 5'd5;
    localparam logic [IDX_W-1:0] IDX_TSTAMP     = 5'd6;
    localparam logic [IDX_W-1:0] IDX_DBG_STAT   = 5'd11;
    localparam logic [IDX_W-1:0] IDX_DBG_CTRL   = 5'd12;
    localparam logic [IDX_W-1:0] IDX_STAT_ALIAS = 5'd13;
    localparam logic [IDX_W-1:0] IDX_CTRL_ALIAS = 5'd14;
    localparam logic [IDX_W-1:0] IDX_FP_TOP     = 5'd15;
    localparam logic [IDX_W-1:0] IDX_FP_TAG     = 5'd16;
    localparam logic [IDX_W-1:0] IDX_FP_STATUS  = 5'd17;
    localparam logic [IDX_W-1:0] IDX_FP_CONTROL = 5'd18;
    localparam logic [IDX_W-1:0] IDX_FP_OPCODE  = 5'd19;
    localparam logic [IDX_W-1:0] IDX_VEC_CSR    = 5'd20;

    // bit positions other logic decodes
    localparam int MODE_PG = 31;
    localparam int MODE_ET = 4;
    localparam int EXT_LME = 8;
    localparam int EXT_LMA = 10;
    localparam int FP_TOP_LSB = 11;
    localparam int FP_TOP_W   = 3;

    localparam logic [XLEN-1:0] FEAT_FLUSH_BITS = 64'h0000_0000_0000_00B0;
    localparam logic [XLEN-1:0] DBG_STAT_WBITS  = 64'h0000_0000_0000_E00F;
    localparam logic [XLEN-1:0] DBG_STAT_RST    = 64'h0000_0000_FFFF_0FF0;
    localparam logic [XLEN-1:0] DBG_CTRL_RST    = 64'h0000_0000_0000_0400;

    typedef struct packed {
        logic             commit;
        logic [IDX_W-1:0] idx;
        logic [XLEN-1:0]  data;
        logic             ext_we;
        logic [XLEN-1:0]  ext_data;
        logic             flush_all;
        logic             flush_ng;
    } wr_cmd_t;

    function automatic logic [IDX_W-1:0] resolve_idx(input logic [IDX_W-1:0] i);
        case (i)
            IDX_STAT_ALIAS: return IDX_DBG_STAT;
            IDX_CTRL_ALIAS: return IDX_DBG_CTRL;
            default:        return i;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] write_mask(input logic [IDX_W-1:0] i);
        case (i)
            IDX_FP_TOP:     return {{(XLEN-3){1'b0}}, 3'h7};
            IDX_FP_TAG:     return {{(XLEN-8){1'b0}}, 8'hFF};
            IDX_FP_STATUS,
            IDX_FP_CONTROL,
            IDX_FP_OPCODE:  return {{(XLEN-16){1'b0}}, 16'hFFFF};
            IDX_VEC_CSR:    return {{(XLEN-32){1'b0}}, 32'hFFFF_FFFF};
            default:        return {XLEN{1'b1}};
        endcase
    endfunction

    function automatic logic [XLEN-1:0] reset_value(input int i);
        if (i == int'(IDX_DBG_STAT)) return DBG_STAT_RST;
        if (i == int'(IDX_DBG_CTRL)) return DBG_CTRL_RST;
        return '0;
    endfunction

endpackage

// File: rtl/crf_write_path.sv
module crf_write_path
    import crf_pkg::*;
(
    input  logic             wr_valid_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [XLEN-1:0]  wr_data_i,
    input  logic [XLEN-1:0]  mode_q_i,
    input  logic [XLEN-1:0]  feat_q_i,
    input  logic [XLEN-1:0]  ext_q_i,
    input  logic [XLEN-1:0]  dbg_stat_q_i,
    input  logic [XLEN-1:0]  cycle_q_i,
    output wr_cmd_t          cmd_o
);

    logic [IDX_W-1:0] tgt;
    logic [XLEN-1:0]  raw;
    logic             pg_toggle;

    always_comb begin
        cmd_o     = '0;
        tgt       = resolve_idx(wr_idx_i);
        raw       = wr_data_i;
        pg_toggle = 1'b0;

        cmd_o.commit   = wr_valid_i && (wr_idx_i < IDX_W'(NUM_REGS));
        cmd_o.idx      = tgt;
        cmd_o.ext_data = ext_q_i;

        case (tgt)
            IDX_MODE: begin
                pg_toggle       = mode_q_i[MODE_PG] ^ wr_data_i[MODE_PG];
                raw[MODE_ET]    = 1'b1;
                cmd_o.flush_all = pg_toggle;
                if (pg_toggle && ext_q_i[EXT_LME]) begin
                    cmd_o.ext_we            = 1'b1;
                    cmd_o.ext_data[EXT_LMA] = wr_data_i[MODE_PG];
                end
            end
            IDX_TABLE_BASE: cmd_o.flush_ng  = 1'b1;
            IDX_FEATURE:    cmd_o.flush_all = |((feat_q_i ^ wr_data_i) & FEAT_FLUSH_BITS);
            IDX_TSTAMP:     raw = wr_data_i - cycle_q_i;
            IDX_DBG_STAT:   raw = (dbg_stat_q_i & ~DBG_STAT_WBITS) | (wr_data_i & DBG_STAT_WBITS);
            default: ;
        endcase

        cmd_o.data = raw & write_mask(tgt);

        if (!cmd_o.commit) begin
            cmd_o.ext_we    = 1'b0;
            cmd_o.flush_all = 1'b0;
            cmd_o.flush_ng  = 1'b0;
        end
    end

endmodule

// File: rtl/crf_read_path.sv
module crf_read_path
    import crf_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             rd_valid_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    input  logic [XLEN-1:0]  regs_i [NUM_REGS],
    input  logic [XLEN-1:0]  cycle_q_i,
    output logic             rd_valid_o,
    output logic [XLEN-1:0]  rd_data_o
);

    logic [IDX_W-1:0] src;
    logic [XLEN-1:0]  value;

    always_comb begin
        src   = resolve_idx(rd_idx_i);
        value = '0;
        if (rd_idx_i < IDX_W'(NUM_REGS)) begin
            value = regs_i[src];
            if (src == IDX_TSTAMP)
                value = value + cycle_q_i;
            if (src == IDX_FP_STATUS)
                value[FP_TOP_LSB +: FP_TOP_W] = regs_i[IDX_FP_TOP][FP_TOP_W-1:0];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
        end else begin
            rd_valid_o <= rd_valid_i;
            rd_data_o  <= rd_valid_i ? value : '0;
        end
    end

    AST_READ_LATENCY: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_valid_i |=> rd_valid_o); // R12

endmodule

// File: rtl/crf_flush_gen.sv
module crf_flush_gen #(
    parameter int N_PORTS = 2
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               req_all_i,
    input  logic               req_ng_i,
    output logic [N_PORTS-1:0] flush_all_o,
    output logic [N_PORTS-1:0] flush_ng_o
);

    for (genvar g = 0; g < N_PORTS; g++) begin : g_port
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                flush_all_o[g] <= 1'b0;
                flush_ng_o[g]  <= 1'b0;
            end else begin
                flush_all_o[g] <= req_all_i;
                flush_ng_o[g]  <= req_ng_i && !req_all_i;
            end
        end

        AST_FLUSH_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (rst_i)
            !(flush_all_o[g] && flush_ng_o[g])); // R7
    end

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
    import crf_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             wr_valid_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [XLEN-1:0]  wr_data_i,
    input  logic             rd_valid_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic             rd_valid_o,
    output logic [XLEN-1:0]  rd_data_o,
    output logic             flush_all_itlb_o,
    output logic             flush_all_dtlb_o,
    output logic             flush_ng_itlb_o,
    output logic             flush_ng_dtlb_o
);

    logic [XLEN-1:0]  regs [NUM_REGS];
    logic [XLEN-1:0]  cycle_q;
    wr_cmd_t          cmd;
    logic [N_TLB-1:0] flush_all;
    logic [N_TLB-1:0] flush_ng;

    always_ff @(posedge clk_i) begin
        if (rst_i) cycle_q <= '0;
        else       cycle_q <= cycle_q + 1'b1;
    end

    crf_write_path u_write (
        .wr_valid_i   (wr_valid_i),
        .wr_idx_i     (wr_idx_i),
        .wr_data_i    (wr_data_i),
        .mode_q_i     (regs[IDX_MODE]),
        .feat_q_i     (regs[IDX_FEATURE]),
        .ext_q_i      (regs[IDX_EXT_FEAT]),
        .dbg_stat_q_i (regs[IDX_DBG_STAT]),
        .cycle_q_i    (cycle_q),
        .cmd_o        (cmd)
    );

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk_i) begin
            if (rst_i)
                regs[g] <= reset_value(g);
            else if (cmd.commit && cmd.idx == IDX_W'(g))
                regs[g] <= cmd.data;
            else if (IDX_W'(g) == IDX_EXT_FEAT && cmd.ext_we)
                regs[g] <= cmd.ext_data;
        end
    end

    crf_read_path u_read (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .rd_valid_i (rd_valid_i),
        .rd_idx_i   (rd_idx_i),
        .regs_i     (regs),
        .cycle_q_i  (cycle_q),
        .rd_valid_o (rd_valid_o),
        .rd_data_o  (rd_data_o)
    );

    crf_flush_gen #(.N_PORTS(N_TLB)) u_flush (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .req_all_i   (cmd.flush_all),
        .req_ng_i    (cmd.flush_ng),
        .flush_all_o (flush_all),
        .flush_ng_o  (flush_ng)
    );

    assign flush_all_itlb_o = flush_all[0];
    assign flush_all_dtlb_o = flush_all[1];
    assign flush_ng_itlb_o  = flush_ng[0];
    assign flush_ng_dtlb_o  = flush_ng[1];

    AST_ET_FORCED: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_valid_i && wr_idx_i == IDX_MODE) |=> regs[IDX_MODE][MODE_ET]); // R3

    AST_LMA_FOLLOWS_PG: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_valid_i && wr_idx_i == IDX_MODE && regs[IDX_EXT_FEAT][EXT_LME]
         && (regs[IDX_MODE][MODE_PG] != wr_data_i[MODE_PG]))
        |=> (regs[IDX_EXT_FEAT][EXT_LMA] == $past(wr_data_i[MODE_PG]))); // R4

    AST_TABLE_FLUSH: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_valid_i && wr_idx_i == IDX_TABLE_BASE) |=> (flush_ng_itlb_o && flush_ng_dtlb_o)); // R5

    AST_FLUSH_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (rst_i)
        (flush_all_itlb_o || flush_ng_itlb_o) |-> $past(wr_valid_i)); // R7

    AST_TOP_WIDTH: assert property (@(posedge clk_i) disable iff (rst_i)
        regs[IDX_FP_TOP][XLEN-1:FP_TOP_W] == '0); // R2

    AST_DBG_STAT_FIXED: assert property (@(posedge clk_i) disable iff (rst_i)
        (regs[IDX_DBG_STAT][11:4] == 8'hFF) && (regs[IDX_DBG_STAT][31:16] == 16'hFFFF)); // R10

endmodule

// File: tb/sysctl_regfile_bench.sv
module sysctl_regfile_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_valid;
    logic [4:0]  wr_idx;
    logic [63:0] wr_data;
    logic        rd_valid;
    logic [4:0]  rd_idx;
    logic        rd_valid_o;
    logic [63:0] rd_data_o;
    logic        fa_i, fa_d, fn_i, fn_d;

    int total  = 0;
    int failed = 0;
    bit done   = 0;

    logic [63:0] m [21];
    logic [63:0] cyc;

    always #10 clk = ~clk;

    sysctl_regfile u_sysctl_regfile (
        .clk_i(clk), .rst_i(rst),
        .wr_valid_i(wr_valid), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
        .rd_valid_i(rd_valid), .rd_idx_i(rd_idx),
        .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
        .flush_all_itlb_o(fa_i), .flush_all_dtlb_o(fa_d),
        .flush_ng_itlb_o(fn_i), .flush_ng_dtlb_o(fn_d)
    );

    task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic int alias_of(input int i);
        if (i == 13) return 11;
        if (i == 14) return 12;
        return i;
    endfunction

    function automatic logic [63:0] model_read(input int i);
        logic [63:0] v;
        int t;
        if (i >= 21) return 64'h0;
        t = alias_of(i);
        v = m[t];
        if (t == 6)  v = v + cyc;
        if (t == 17) v[13:11] = m[15][2:0];
        return v;
    endfunction

    task automatic model_write(input int i, input logic [63:0] din, output bit fa, output bit fn);
        logic [63:0] d;
        int t;
        fa = 0; fn = 0; d = din;
        if (i >= 21) return;
        t = alias_of(i);
        case (t)
            0: begin
                if (m[0][31] != d[31]) begin
                    fa = 1;
                    if (m[5][8]) m[5][10] = d[31];
                end
                d[4] = 1'b1;
            end
            2:  fn = 1;
            3:  fa = |((m[3] ^ d) & 64'hB0);
            6:  d = d - cyc;
            11: d = (m[11] & ~64'hE00F) | (d & 64'hE00F);
            15: d = d & 64'h7;
            16: d = d & 64'hFF;
            17, 18, 19: d = d & 64'hFFFF;
            20: d = d & 64'hFFFF_FFFF;
            default: ;
        endcase
        m[t] = d;
    endtask

    task automatic step(input bit wv, input int wi, input logic [63:0] wd,
                        input bit rv, input int ri, input string tag);
        logic [63:0] exp_rd;
        bit fa, fn;
        wr_valid = wv; wr_idx = wi[4:0]; wr_data = wd;
        rd_valid = rv; rd_idx = ri[4:0];
        exp_rd = model_read(ri);
        fa = 0; fn = 0;
        if (wv) model_write(wi, wd, fa, fn);
        @(posedge clk);
        cyc = cyc + 1;
        @(negedge clk);
        check(tag, "flush {all_i,all_d,ng_i,ng_d}", {60'h0, fa_i, fa_d, fn_i, fn_d},
              {60'h0, fa, fa, fn && !fa, fn && !fa});
        check(tag, "rd_valid", {63'h0, rd_valid_o}, {63'h0, rv});
        if (rv) check(tag, $sformatf("rd_data idx %0d", ri), rd_data_o, exp_rd);
    endtask

    task automatic wr(input int i, input logic [63:0] d, input string tag);
        step(1, i, d, 0, 0, tag);
    endtask

    task automatic rd(input int i, input string tag);
        step(0, 0, 64'h0, 1, i, tag);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++; failed++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    initial begin
        rst = 1; wr_valid = 0; wr_idx = 0; wr_data = 0; rd_valid = 0; rd_idx = 0;
        for (int i = 0; i < 21; i++) m[i] = 64'h0;
        m[11] = 64'h0000_0000_FFFF_0FF0;
        m[12] = 64'h0000_0000_0000_0400;
        cyc = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1 reset values
        for (int i = 0; i < 21; i++) rd(i, "R1");

        // R2 masking
        for (int i = 15; i < 21; i++) begin
            wr(i, 64'hFFFF_FFFF_FFFF_FFFF, "R2");
            rd(i, "R2");
        end
        wr(1, 64'hDEAD_BEEF_0123_4567, "R2");
        rd(1, "R2");

        // R3 mode word, no long-mode enable
        wr(0, 64'h0000_0000_8000_0001, "R3");
        rd(0, "R3");
        wr(0, 64'h0000_0000_8000_0000, "R3");
        rd(0, "R3");
        rd(5, "R3");

        // R4 long-mode active follows paging
        wr(5, 64'h100, "R4");
        wr(0, 64'h0, "R4");
        rd(5, "R4");
        wr(0, 64'h8000_0000, "R4");
        rd(5, "R4");
        wr(0, 64'h8000_0011, "R4");
        rd(5, "R4");
        wr(0, 64'h1, "R4");
        rd(5, "R4");

        // R5 table base
        wr(2, 64'h1000, "R5");
        wr(2, 64'h1000, "R5");
        rd(2, "R5");

        // R6 feature toggles
        wr(3, 64'h10, "R6");
        wr(3, 64'h30, "R6");
        wr(3, 64'hB0, "R6");
        wr(3, 64'hB1, "R6");
        wr(3, 64'hB1, "R6");
        wr(3, 64'h01, "R6");
        rd(3, "R6");

        // R7 back-to-back pulses and mixed kinds
        wr(0, 64'h8000_0000, "R7");
        wr(2, 64'h2000, "R7");
        wr(0, 64'h0, "R7");
        step(0, 0, 64'h0, 0, 0, "R7");

        // R8 time-stamp offset
        wr(6, 64'd1000, "R8");
        rd(6, "R8");
        step(0, 0, 64'h0, 0, 0, "R8");
        step(0, 0, 64'h0, 0, 0, "R8");
        rd(6, "R8");
        repeat (7) rd(6, "R8");
        wr(6, 64'h0, "R8");
        rd(6, "R8");

        // R9 aliases
        wr(13, 64'hFFFF_FFFF_FFFF_FFFF, "R9");
        rd(11, "R9");
        rd(13, "R9");
        wr(14, 64'h0000_0000_00FF_0055, "R9");
        rd(12, "R9");
        rd(14, "R9");

        // R10 debug status write mask
        wr(11, 64'h0, "R10");
        rd(11, "R10");
        wr(11, 64'h0000_0000_0000_4002, "R10");
        rd(11, "R10");

        // R11 status with top inserted
        wr(15, 64'h5, "R11");
        wr(17, 64'hFFFF, "R11");
        rd(17, "R11");
        wr(17, 64'h0, "R11");
        rd(17, "R11");
        wr(15, 64'h2, "R11");
        rd(17, "R11");

        // R12 read-before-write and out-of-range indices
        step(1, 4, 64'hAA, 1, 4, "R12");
        rd(4, "R12");
        wr(25, 64'hFFFF_FFFF_FFFF_FFFF, "R12");
        rd(25, "R12");
        rd(31, "R12");
        for (int i = 0; i < 21; i++) rd(i, "R12");

        done = 1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

endmodule